// File: doc/BRIEF.md
# Parallel Slave Port Controller

This block lets an external microprocessor exchange bytes with an on-chip CPU over an 8-bit bus. The external side has three active-low control pins: chip select, write strobe and read strobe. The on-chip side uses a small register interface with four addresses. Address 0 is the data byte. Address 1 is a combined status, mode and direction register. Address 2 is the general-purpose pin latch and pin readback.

A mode bit chooses what the three control pins do. With the mode bit set, they carry the slave-port handshake. With it clear, they are general-purpose I/O pins, and each pin has its own direction bit. The external strobes are asynchronous, so they pass through a two-flop synchronizer before any edge detection.

In slave mode, an external write leaves a byte for the CPU and sets an input-full flag. A CPU write leaves a byte for the external master and sets an output-full flag. A sticky overflow flag records any external write that lands on a byte the CPU has not yet read.

Top module: `pslv_port`

## Requirements
- R1: After reset, address 1 reads 0x07 (all directions input, I/O mode, all flags clear), and bus_oe and pin_oe are all 0.
- R2: Address 1 holds these bits: bit 7 input-full, bit 6 output-full, bit 5 overflow, bit 4 mode, bit 3 always 0, bits 2:0 directions for pins 2:0. Bits 7 and 6 are read-only, and a CPU write cannot set bit 5. Writing 0xFF from reset therefore reads back 0x17.
- R3: Pin indices are 0 = read strobe, 1 = write strobe, 2 = chip select. In slave mode, an external write is chip select and write strobe both low after synchronization. When that access ends, the last byte sampled from bus_din goes to address 0 and input-full is set. A CPU read of address 0 clears input-full.
- R4: A CPU write to address 0 sets output-full. During an external read (chip select and read strobe both low after synchronization), bus_oe is 1 and bus_dout carries that byte. The end of the read clears output-full.
- R5: An external write that completes while input-full is set, in a cycle without a CPU read of address 0, sets overflow. The new byte still replaces the old one. Overflow stays set until a CPU write to address 1 with bit 5 equal to 0. Writing bit 5 as 1 leaves it unchanged.
- R6: In I/O mode, pin_oe[i] is the inverse of direction bit i, and pin_out carries bits 2:0 of the pin latch at address 2. Reading address 2 returns the synchronized pin levels in bits 2:0, with the upper bits 0. In slave mode, pin_oe is all 0.
- R7: In I/O mode, strobe activity on the pins captures nothing, changes no flag and never drives the bus.
- R8: In slave mode with any direction bit 0, the strobes are treated as inactive: no capture, no flag change, and bus_oe stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 2 | CPU register address |
| reg_wr | input | 1 | CPU write enable |
| reg_rd | input | 1 | CPU read enable (read side effects) |
| reg_wdata | input | 8 | CPU write data |
| reg_rdata | output | 8 | CPU read data (combinational) |
| pin_in | input | 3 | Pin levels: 0 read strobe, 1 write strobe, 2 chip select |
| pin_out | output | 3 | Pin output levels in I/O mode |
| pin_oe | output | 3 | Pin output enables |
| bus_din | input | 8 | External data bus in |
| bus_dout | output | 8 | External data bus out |
| bus_oe | output | 1 | External data bus drive enable |

## Verification
The assertions assume that the CPU interface is synchronous to clk, and that reg_rd and reg_wr are never both high in one cycle. They also assume that bus_din stays stable while a synchronized write access is active. The directed stimulus changes pins and bus data only between clock edges and holds every strobe low for several cycles, so the synchronizer always sees a clean level. It sets bus_din before it lowers the strobes and leaves it unchanged until after the access has ended. The CPU tasks raise a single enable per cycle.

// File: rtl/pslv_pkg.sv
package pslv_pkg;
    localparam int PIN_W   = 3;
    localparam int PIN_RD  = 0;
    localparam int PIN_WR  = 1;
    localparam int PIN_CS  = 2;

    typedef enum logic [1:0] {
        ADDR_DATA = 2'd0,
        ADDR_CTRL = 2'd1,
        ADDR_PINS = 2'd2,
        ADDR_NONE = 2'd3
    } reg_addr_e;

    localparam int BIT_IBF  = 7;
    localparam int BIT_OBF  = 6;
    localparam int BIT_OVF  = 5;
    localparam int BIT_MODE = 4;
endpackage

// File: rtl/pslv_sync.sv
module pslv_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    logic [STAGES-1:0][W-1:0] chain_q;

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    chain_q[s] <= '1;
                end else if (s == 0) begin
                    chain_q[s] <= async_in;
                end else begin
                    chain_q[s] <= chain_q[(s == 0) ? 0 : s-1];
                end
            end
        end
    endgenerate

    assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/pslv_strobe.sv
module pslv_strobe (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic cs_n,
    input  logic wr_n,
    input  logic rd_n,
    output logic wr_act,
    output logic rd_act,
    output logic wr_end,
    output logic rd_end
);
    typedef struct packed {
        logic wr_prev;
        logic rd_prev;
    } strobe_t;

    strobe_t st_d, st_q;
    logic wr_raw, rd_raw;

    always_comb begin
        wr_raw = !cs_n && !wr_n;
        rd_raw = !cs_n && !rd_n;
        wr_act = enable && wr_raw;
        rd_act = enable && rd_raw;
        wr_end = enable && st_q.wr_prev && !wr_raw;
        rd_end = enable && st_q.rd_prev && !rd_raw;
        st_d.wr_prev = wr_act;
        st_d.rd_prev = rd_act;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/pslv_regs.sv
module pslv_regs
    import pslv_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       addr,
    input  logic             wr,
    input  logic             rd,
    input  logic [DW-1:0]    wdata,
    output logic [DW-1:0]    rdata,
    input  logic [PIN_W-1:0] pin_sync,
    input  logic [DW-1:0]    bus_din,
    input  logic             wr_act,
    input  logic             wr_end,
    input  logic             rd_end,
    output logic             ibf,
    output logic             obf,
    output logic             ibov,
    output logic             mode,
    output logic [PIN_W-1:0] dir,
    output logic [PIN_W-1:0] pin_lat,
    output logic [DW-1:0]    out_data
);
    typedef struct packed {
        logic [DW-1:0]    in_data;
        logic [DW-1:0]    out_data;
        logic [DW-1:0]    hold;
        logic             ibf;
        logic             obf;
        logic             ibov;
        logic             mode;
        logic [PIN_W-1:0] dir;
        logic [PIN_W-1:0] pin_lat;
    } regs_t;

    regs_t r_d, r_q;
    logic  cpu_rd_data, cpu_wr_data, cpu_wr_ctrl, cpu_wr_pins;
    logic [7:0] status;

    always_comb begin
        cpu_rd_data = rd && (addr == ADDR_DATA);
        cpu_wr_data = wr && (addr == ADDR_DATA);
        cpu_wr_ctrl = wr && (addr == ADDR_CTRL);
        cpu_wr_pins = wr && (addr == ADDR_PINS);

        r_d = r_q;

        if (wr_act) r_d.hold = bus_din;

        if (cpu_wr_ctrl) begin
            r_d.mode = wdata[BIT_MODE];
            r_d.dir  = wdata[PIN_W-1:0];
            r_d.ibov = r_q.ibov && wdata[BIT_OVF];
        end
        if (cpu_wr_pins) r_d.pin_lat = wdata[PIN_W-1:0];

        if (cpu_rd_data) r_d.ibf = 1'b0;
        if (wr_end) begin
            r_d.in_data = r_q.hold;
            r_d.ibf     = 1'b1;
            if (r_q.ibf && !cpu_rd_data) r_d.ibov = 1'b1;
        end

        if (rd_end) r_d.obf = 1'b0;
        if (cpu_wr_data) begin
            r_d.out_data = wdata;
            r_d.obf      = 1'b1;
        end

        status = {r_q.ibf, r_q.obf, r_q.ibov, r_q.mode, 1'b0, r_q.dir};
        case (addr)
            ADDR_DATA: rdata = r_q.in_data;
            ADDR_CTRL: rdata = DW'(status);
            ADDR_PINS: rdata = DW'(pin_sync);
            default:   rdata = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q         <= '0;
            r_q.dir     <= '1;
        end else begin
            r_q <= r_d;
        end
    end

    assign ibf      = r_q.ibf;
    assign obf      = r_q.obf;
    assign ibov     = r_q.ibov;
    assign mode     = r_q.mode;
    assign dir      = r_q.dir;
    assign pin_lat  = r_q.pin_lat;
    assign out_data = r_q.out_data;
endmodule

// File: rtl/pslv_port.sv
module pslv_port
    import pslv_pkg::*;
#(
    parameter int DW          = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       reg_addr,
    input  logic             reg_wr,
    input  logic             reg_rd,
    input  logic [DW-1:0]    reg_wdata,
    output logic [DW-1:0]    reg_rdata,
    input  logic [PIN_W-1:0] pin_in,
    output logic [PIN_W-1:0] pin_out,
    output logic [PIN_W-1:0] pin_oe,
    input  logic [DW-1:0]    bus_din,
    output logic [DW-1:0]    bus_dout,
    output logic             bus_oe
);
    logic [PIN_W-1:0] pin_sync;
    logic             wr_act, rd_act, wr_end, rd_end;
    logic             ibf, obf, ibov, mode;
    logic [PIN_W-1:0] dir, pin_lat;
    logic [DW-1:0]    out_data;
    logic             port_en;

    pslv_sync #(.W(PIN_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_in(pin_in), .sync_out(pin_sync)
    );

    assign port_en = mode && (&dir);

    pslv_strobe u_strobe (
        .clk(clk), .rst_n(rst_n), .enable(port_en),
        .cs_n(pin_sync[PIN_CS]), .wr_n(pin_sync[PIN_WR]), .rd_n(pin_sync[PIN_RD]),
        .wr_act(wr_act), .rd_act(rd_act), .wr_end(wr_end), .rd_end(rd_end)
    );

    pslv_regs #(.DW(DW)) u_regs (
        .clk(clk), .rst_n(rst_n), .addr(reg_addr), .wr(reg_wr), .rd(reg_rd),
        .wdata(reg_wdata), .rdata(reg_rdata), .pin_sync(pin_sync),
        .bus_din(bus_din), .wr_act(wr_act), .wr_end(wr_end), .rd_end(rd_end),
        .ibf(ibf), .obf(obf), .ibov(ibov), .mode(mode), .dir(dir),
        .pin_lat(pin_lat), .out_data(out_data)
    );

    assign pin_out  = pin_lat;
    assign pin_oe   = mode ? '0 : ~dir;
    assign bus_dout = out_data;
    assign bus_oe   = rd_act;
endmodule

// File: rtl/pslv_port_chk.sv
module pslv_port_chk #(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic [1:0]    reg_addr,
    input logic          reg_wr,
    input logic          reg_rd,
    input logic [DW-1:0] reg_wdata,
    input logic          wr_end,
    input logic          rd_end,
    input logic          ibf,
    input logic          obf,
    input logic          ibov,
    input logic          mode,
    input logic [2:0]    dir,
    input logic [2:0]    pin_oe,
    input logic          bus_oe
);
    // R3: a completed external write leaves input-full set
    p_ibf_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_end |=> ibf);

    // R5: a write onto an unread byte raises overflow
    p_ovf_raise_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_end && ibf && !(reg_rd && reg_addr == 2'd0)) |=> ibov);

    // R5: overflow only falls after a clearing control write
    p_ovf_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ibov && !(reg_wr && reg_addr == 2'd1 && !reg_wdata[5])) |=> ibov);

    // R4: end of an external read empties the output buffer
    p_obf_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_end && !(reg_wr && reg_addr == 2'd0)) |=> !obf);

    // R7 / R8: bus driven only in a valid slave configuration
    p_bus_guard_r8: assert property (@(posedge clk) disable iff (!rst_n)
        bus_oe |-> (mode && dir == 3'b111));

    // R6: no pin driven in slave mode
    p_pins_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mode |-> (pin_oe == 3'b000));
endmodule

bind pslv_port pslv_port_chk #(.DW(DW)) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_wdata(reg_wdata), .wr_end(wr_end), .rd_end(rd_end),
    .ibf(ibf), .obf(obf), .ibov(ibov), .mode(mode), .dir(dir),
    .pin_oe(pin_oe), .bus_oe(bus_oe)
);

// File: tb/pslv_port_test.sv
module pslv_port_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] reg_addr = 2'd3;
    logic       reg_wr = 1'b0;
    logic       reg_rd = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic [2:0] pin_in = 3'b111;
    logic [2:0] pin_out, pin_oe;
    logic [7:0] bus_din = 8'h00;
    logic [7:0] bus_dout;
    logic       bus_oe;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    pslv_port uut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
        .bus_din(bus_din), .bus_dout(bus_dout), .bus_oe(bus_oe)
    );

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) @(posedge clk);
        #1;
    endtask

    task automatic cpu_write(logic [1:0] a, logic [7:0] d);
        @(posedge clk); #1;
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(posedge clk); #1;
        reg_wr = 1'b0; reg_addr = 2'd3;
    endtask

    task automatic cpu_read(logic [1:0] a, output logic [7:0] d);
        @(posedge clk); #1;
        reg_addr = a; reg_rd = 1'b1;
        @(negedge clk);
        d = reg_rdata;
        @(posedge clk); #1;
        reg_rd = 1'b0; reg_addr = 2'd3;
    endtask

    // pin order: bit0 read strobe, bit1 write strobe, bit2 chip select
    task automatic ext_write(logic [7:0] d);
        @(posedge clk); #1;
        bus_din = d;
        idle(1);
        pin_in = 3'b001;
        idle(5);
        pin_in = 3'b111;
        idle(6);
    endtask

    task automatic ext_read(output logic oe, output logic [7:0] d);
        @(posedge clk); #1;
        pin_in = 3'b010;
        idle(5);
        @(negedge clk);
        oe = bus_oe; d = bus_dout;
        @(posedge clk); #1;
        pin_in = 3'b111;
        idle(6);
    endtask

    task automatic t_reset;
        logic [7:0] v;
        cpu_read(2'd1, v);
        check("R1 status", v, 8'h07);
        check("R1 bus_oe", {7'b0, bus_oe}, 8'h00);
        check("R1 pin_oe", {5'b0, pin_oe}, 8'h00);
    endtask

    task automatic t_layout;
        logic [7:0] v;
        cpu_write(2'd1, 8'hFF);
        cpu_read(2'd1, v);
        check("R2 readonly/bit3", v, 8'h17);
        check("R6 pin_oe slave", {5'b0, pin_oe}, 8'h00);
        cpu_write(2'd1, 8'h07);
    endtask

    task automatic t_io_mode;
        logic [7:0] v;
        logic       oe;
        cpu_write(2'd1, 8'h05);
        check("R6 pin_oe", {5'b0, pin_oe}, 8'h02);
        cpu_write(2'd2, 8'h02);
        check("R6 pin_out", {5'b0, pin_out}, 8'h02);
        pin_in = 3'b101;
        idle(4);
        cpu_read(2'd2, v);
        check("R6 pin readback", v, 8'h05);
        pin_in = 3'b111;
        idle(4);
        cpu_write(2'd1, 8'h07);
        ext_write(8'hAA);
        cpu_read(2'd1, v);
        check("R7 io mode no capture", v, 8'h07);
        cpu_read(2'd0, v);
        check("R7 data unchanged", v, 8'h00);
        ext_read(oe, v);
        check("R7 no bus drive", {7'b0, oe}, 8'h00);
    endtask

    task automatic t_bad_dir;
        logic [7:0] v;
        logic       oe;
        cpu_write(2'd1, 8'h16);
        ext_write(8'h33);
        cpu_read(2'd1, v);
        check("R8 strobes ignored", v, 8'h16);
        ext_read(oe, v);
        check("R8 no bus drive", {7'b0, oe}, 8'h00);
    endtask

    task automatic t_write;
        logic [7:0] v;
        cpu_write(2'd1, 8'h17);
        ext_write(8'h5A);
        cpu_read(2'd1, v);
        check("R3 ibf set", v, 8'h97);
        cpu_read(2'd0, v);
        check("R3 byte", v, 8'h5A);
        cpu_read(2'd1, v);
        check("R3 ibf cleared", v, 8'h17);
    endtask

    task automatic t_read;
        logic [7:0] v;
        logic       oe;
        cpu_write(2'd0, 8'hC3);
        cpu_read(2'd1, v);
        check("R4 obf set", v, 8'h57);
        ext_read(oe, v);
        check("R4 bus_oe", {7'b0, oe}, 8'h01);
        check("R4 bus_dout", v, 8'hC3);
        cpu_read(2'd1, v);
        check("R4 obf cleared", v, 8'h17);
        check("R4 bus released", {7'b0, bus_oe}, 8'h00);
    endtask

    task automatic t_overflow;
        logic [7:0] v;
        ext_write(8'h11);
        ext_write(8'h22);
        cpu_read(2'd1, v);
        check("R5 overflow", v, 8'hB7);
        cpu_read(2'd0, v);
        check("R5 overwrite", v, 8'h22);
        cpu_read(2'd1, v);
        check("R5 sticky", v, 8'h37);
        cpu_write(2'd1, 8'h37);
        cpu_read(2'd1, v);
        check("R5 write 1 keeps", v, 8'h37);
        cpu_write(2'd1, 8'h17);
        cpu_read(2'd1, v);
        check("R5 cleared", v, 8'h17);
    endtask

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(2);
        t_reset();
        t_layout();
        t_io_mode();
        t_bad_dir();
        t_write();
        t_read();
        t_overflow();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_checks++;
                n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule